// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Receive Status

This block turns an asynchronous serial line into received characters. It watches the idle-high line for a falling edge, confirms the start bit at its midpoint and then samples every later bit at its centre, timed by an enable tick running at the oversampling rate (sixteen ticks per bit by default). Each character carries 7 or 8 data bits, least significant bit first. An optional parity bit with even or odd sense follows, then one or two stop bits.

At the end of a character the receiver checks parity, the first stop bit, and whether the previous character has been consumed. A clean character is placed in the data register and the data-full flag is raised. A failed check raises the matching error flag instead, and the receiver then ignores the line until software clears every error flag. Each flag has its own write-one-to-clear strobe, and a data-register read strobe also clears the data-full flag. Two interrupt requests, one for data-full and one for errors, are gated by a single enable.

Top module: `serial_rx_status`

## Requirements
- R1: A low line level seen while idle starts a character only if the line is still low at the start bit's midpoint, which is OVS/2 ticks after detection. Otherwise the receiver goes back to idle and no flag or data changes. `busy` is 1 from a confirmed start until the end of the last stop bit.
- R2: Data bits arrive least significant first. Frame bit k lands in `rx_data[k]`. With `cfg_seven` = 1, seven bits are received and `rx_data[7]` reads 0.
- R3: With `cfg_par_en` = 1 the number of ones across the data bits and the parity bit must be even when `cfg_par_odd` = 0, or odd when it is 1. A mismatch sets `par_err`.
- R4: A first stop bit sampled as 0 sets `frm_err`. With `cfg_two_stop` = 1 the second stop bit is not checked, so a 0 there causes no error.
- R5: A character that passes every check sets `rx_full` and is written to `rx_data`.
- R6: A character that completes while `rx_full` is 1 sets `ovr_err`. `rx_data` keeps the earlier character and `rx_full` stays 1.
- R7: A character with a parity or framing error does not set `rx_full` and does not change `rx_data`. While any error flag is 1, no new character starts.
- R8: `clr_full`, `clr_ovr`, `clr_par` and `clr_frm` each clear only their own flag when pulsed high. `rd_strobe` also clears `rx_full`.
- R9: `irq_full` = `irq_en` AND `rx_full`. `irq_err` = `irq_en` AND (any error flag).
- R10: After synchronous reset, all flags, `rx_data`, `busy` and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, OVS ticks per bit |
| rx_line | input | 1 | Serial line, idle high |
| cfg_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | Two stop bits |
| irq_en | input | 1 | Interrupt request enable |
| clr_full | input | 1 | Clear data-full flag |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_par | input | 1 | Clear parity error flag |
| clr_frm | input | 1 | Clear framing error flag |
| rd_strobe | input | 1 | Data register read, clears data-full |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Data-full flag |
| ovr_err | output | 1 | Overrun flag |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| busy | output | 1 | Character in progress |
| irq_full | output | 1 | Data-full interrupt request |
| irq_err | output | 1 | Receive error interrupt request |

## Verification
The hardest situation to create is the blocked receiver: an error flag must already be set, and a complete, well-formed character must then arrive and be ignored. The bench first forces an overrun by sending two clean characters with no read between them. It then sends a third character and watches `busy` halfway through it and `rx_data` afterwards. Only after clearing the flags does it show that a new character is accepted. A glitch shorter than half a bit and a low second stop bit are sent as separate directed cases.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SRX_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } srx_state_e;

    typedef struct packed {
        logic seven;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } srx_cfg_t;

    typedef struct packed {
        logic [SRX_DATA_W-1:0] data;
        logic                  par_ok;
        logic                  stop_ok;
    } srx_result_t;

    function automatic logic parity_good(input logic [SRX_DATA_W-1:0] d,
                                         input logic pbit, input logic odd);
        return ((^d) ^ pbit) == odd;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b1;
                else if (i == 0)
                    chain[i] <= din;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        rx_s,
    input  logic        hold,
    input  srx_cfg_t    cfg,
    output logic        busy,
    output logic        done,
    output srx_result_t result
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(SRX_DATA_W);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);

    srx_state_e            state;
    logic [CNT_W-1:0]      cnt;
    logic [IDX_W-1:0]      idx;
    logic [SRX_DATA_W-1:0] shreg;
    logic                  par_bit;
    logic                  stop_bit;
    logic [IDX_W-1:0]      last_idx;
    logic                  bit_end;

    assign last_idx = cfg.seven ? IDX_W'(SRX_DATA_W-2) : IDX_W'(SRX_DATA_W-1);
    assign bit_end  = (cnt == FULL_M1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            stop_bit <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                cnt <= cnt + 1'b1;
                unique case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (!rx_s && !hold) begin
                            state <= ST_START;
                            shreg <= '0;
                        end
                    end
                    ST_START: if (cnt == HALF_M1) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= rx_s ? ST_IDLE : ST_DATA;
                    end
                    ST_DATA: if (bit_end) begin
                        shreg[idx] <= rx_s;
                        idx        <= idx + 1'b1;
                        if (idx == last_idx)
                            state <= cfg.par_en ? ST_PAR : ST_STOP;
                    end
                    ST_PAR: if (bit_end) begin
                        par_bit <= rx_s;
                        state   <= ST_STOP;
                    end
                    ST_STOP: if (bit_end) begin
                        stop_bit <= rx_s;
                        done     <= 1'b1;
                        state    <= cfg.two_stop ? ST_STOP2 : ST_IDLE;
                    end
                    ST_STOP2: if (bit_end) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy           = (state != ST_IDLE) && (state != ST_START);
    assign result.data    = shreg;
    assign result.stop_ok = stop_bit;
    assign result.par_ok  = !cfg.par_en || parity_good(shreg, par_bit, cfg.par_odd);
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  done,
    input  srx_result_t           result,
    input  logic                  clr_full,
    input  logic                  clr_ovr,
    input  logic                  clr_par,
    input  logic                  clr_frm,
    input  logic                  rd_strobe,
    output logic [SRX_DATA_W-1:0] rx_data,
    output logic                  rx_full,
    output logic                  ovr_err,
    output logic                  par_err,
    output logic                  frm_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            ovr_err <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            if (clr_full || rd_strobe) rx_full <= 1'b0;
            if (clr_ovr) ovr_err <= 1'b0;
            if (clr_par) par_err <= 1'b0;
            if (clr_frm) frm_err <= 1'b0;
            if (done) begin
                if (rx_full)         ovr_err <= 1'b1;
                if (!result.par_ok)  par_err <= 1'b1;
                if (!result.stop_ok) frm_err <= 1'b1;
                if (!rx_full && result.par_ok && result.stop_ok) begin
                    rx_data <= result.data;
                    rx_full <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import srx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  rx_line,
    input  logic                  cfg_seven,
    input  logic                  cfg_par_en,
    input  logic                  cfg_par_odd,
    input  logic                  cfg_two_stop,
    input  logic                  irq_en,
    input  logic                  clr_full,
    input  logic                  clr_ovr,
    input  logic                  clr_par,
    input  logic                  clr_frm,
    input  logic                  rd_strobe,
    output logic [SRX_DATA_W-1:0] rx_data,
    output logic                  rx_full,
    output logic                  ovr_err,
    output logic                  par_err,
    output logic                  frm_err,
    output logic                  busy,
    output logic                  irq_full,
    output logic                  irq_err
);
    logic        rx_s;
    logic        done;
    logic        any_err;
    srx_cfg_t    cfg;
    srx_result_t result;

    assign cfg     = '{seven: cfg_seven, par_en: cfg_par_en,
                       par_odd: cfg_par_odd, two_stop: cfg_two_stop};
    assign any_err = ovr_err | par_err | frm_err;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rx_line), .dout(rx_s)
    );

    srx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst(rst), .tick(tick), .rx_s(rx_s), .hold(any_err),
        .cfg(cfg), .busy(busy), .done(done), .result(result)
    );

    srx_status u_status (
        .clk(clk), .rst(rst), .done(done), .result(result),
        .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_par(clr_par),
        .clr_frm(clr_frm), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_full(rx_full), .ovr_err(ovr_err), .par_err(par_err),
        .frm_err(frm_err)
    );

    assign irq_full = irq_en & rx_full;
    assign irq_err  = irq_en & any_err;
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       ovr_err,
    input logic       par_err,
    input logic       frm_err,
    input logic       busy,
    input logic       rd_strobe,
    input logic       irq_en,
    input logic       irq_full,
    input logic       irq_err
);
    // R5: the data register only changes as a clean character lands
    p_data_with_full_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_full);

    // R6: overrun leaves the stored character alone
    p_ovr_keeps_data_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_err) |-> $stable(rx_data));

    // R7: errored character never raises data-full
    p_err_no_full_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(par_err) || $rose(frm_err)) |-> !$rose(rx_full));

    // R7: receiver stays idle while an error is pending
    p_block_r7: assert property (@(posedge clk) disable iff (rst)
        ((ovr_err || par_err || frm_err) && !busy) |=> !busy);

    // R8: a read empties the data register flag
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rx_full) |=> !rx_full);

    // R9: interrupt requests follow their flags when enabled
    p_irq_full_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_full) && irq_en) |-> irq_full);
    p_irq_err_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(par_err) && irq_en) |-> irq_err);
endmodule

bind serial_rx_status srx_checker u_chk (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_full(rx_full),
    .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err), .busy(busy),
    .rd_strobe(rd_strobe), .irq_en(irq_en), .irq_full(irq_full),
    .irq_err(irq_err)
);

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int NV         = 9;

    // {data[16:9], seven[8], par_en[7], odd[6], two_stop[5], bad_par[4], bad_stop[3],
    //  exp_full[2], exp_par[1], exp_frm[0]}
    localparam logic [16:0] VEC [NV] = '{
        {8'hA5, 6'b000000, 3'b100},
        {8'h3C, 6'b010000, 3'b100},
        {8'h3C, 6'b011000, 3'b100},
        {8'h5B, 6'b110000, 3'b100},
        {8'hC3, 6'b100000, 3'b100},
        {8'h81, 6'b010010, 3'b010},
        {8'h55, 6'b000001, 3'b001},
        {8'h0F, 6'b000100, 3'b100},
        {8'hF0, 6'b011011, 3'b011}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic rx_line = 1'b1;
    logic cfg_seven = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
    logic irq_en = 0;
    logic clr_full = 0, clr_ovr = 0, clr_par = 0, clr_frm = 0, rd_strobe = 0;
    logic [7:0] rx_data;
    logic rx_full, ovr_err, par_err, frm_err, busy, irq_full, irq_err;

    int  n_checks = 0;
    int  n_fails  = 0;
    logic [7:0] prev_data = 8'h00;
    logic mid_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_status dut_i (
        .clk(clk), .rst(rst), .tick(tick), .rx_line(rx_line),
        .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .irq_en(irq_en), .clr_full(clr_full),
        .clr_ovr(clr_ovr), .clr_par(clr_par), .clr_frm(clr_frm),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
        .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err), .busy(busy),
        .irq_full(irq_full), .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        rx_line = v;
        repeat (OVS) @(negedge clk);
    endtask

    // sends one character; samples busy halfway through the data bits
    task automatic send(input logic [7:0] d, input logic seven, input logic pen,
                        input logic odd, input logic two, input logic bpar,
                        input logic stop1, input logic stop2);
        int nb;
        logic p;
        nb = seven ? 7 : 8;
        p  = 1'b0;
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) begin
            if (i == 3) begin
                rx_line = d[i];
                repeat (OVS/2) @(negedge clk);
                mid_busy = busy;
                repeat (OVS/2) @(negedge clk);
            end else begin
                bit_out(d[i]);
            end
            p = p ^ d[i];
        end
        if (pen) bit_out(p ^ odd ^ bpar);
        bit_out(stop1);
        if (two) bit_out(stop2);
        rx_line = 1'b1;
        repeat (OVS + 4) @(negedge clk);
    endtask

    task automatic clear_all();
        rd_strobe = 1; clr_ovr = 1; clr_par = 1; clr_frm = 1;
        @(negedge clk);
        rd_strobe = 0; clr_ovr = 0; clr_par = 0; clr_frm = 0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic s, input logic pe, input logic od, input logic tw);
        cfg_seven = s; cfg_par_en = pe; cfg_par_odd = od; cfg_two_stop = tw;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10 reset state
        chk("R10 data", rx_data, 0);
        chk("R10 flags", {rx_full, ovr_err, par_err, frm_err}, 0);
        chk("R10 busy/irq", {busy, irq_full, irq_err}, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [7:0] d, expd;
            logic s, pe, od, tw, bp, bs, ef, ep, efr;
            {d, s, pe, od, tw, bp, bs, ef, ep, efr} = VEC[v];
            set_cfg(s, pe, od, tw);
            send(d, s, pe, od, tw, bp, ~bs, 1'b1);
            expd = ef ? (s ? {1'b0, d[6:0]} : d) : prev_data;
            chk("R1 busy mid-frame", mid_busy, 1);
            chk("R2/R5 data", rx_data, expd);
            chk("R5/R7 full", rx_full, ef);
            chk("R3 par_err", par_err, ep);
            chk("R4 frm_err", frm_err, efr);
            chk("R6 no overrun", ovr_err, 0);
            prev_data = expd;
            clear_all();
            chk("R8 cleared", {rx_full, ovr_err, par_err, frm_err}, 0);
        end

        // R6 overrun then R7 blocking
        set_cfg(0, 0, 0, 0);
        send(8'h11, 0, 0, 0, 0, 0, 1, 1);
        send(8'h22, 0, 0, 0, 0, 0, 1, 1);
        chk("R6 ovr set", ovr_err, 1);
        chk("R6 full kept", rx_full, 1);
        chk("R6 data kept", rx_data, 8'h11);
        rd_strobe = 1; @(negedge clk); rd_strobe = 0; @(negedge clk);
        chk("R8 read clears full only", {rx_full, ovr_err}, 2'b01);
        send(8'h33, 0, 0, 0, 0, 0, 1, 1);
        chk("R7 blocked busy", mid_busy, 0);
        chk("R7 blocked data", rx_data, 8'h11);
        chk("R7 blocked full", rx_full, 0);
        clr_ovr = 1; @(negedge clk); clr_ovr = 0; @(negedge clk);
        chk("R8 clr_ovr", ovr_err, 0);
        send(8'h44, 0, 0, 0, 0, 0, 1, 1);
        chk("R7 resumes", rx_data, 8'h44);

        // R8 individual clears
        clr_full = 1; @(negedge clk); clr_full = 0; @(negedge clk);
        chk("R8 clr_full", rx_full, 0);
        set_cfg(0, 1, 0, 0);
        send(8'h01, 0, 1, 0, 0, 1, 0, 1);
        chk("R3/R4 both errors", {par_err, frm_err}, 2'b11);
        clr_par = 1; @(negedge clk); clr_par = 0; @(negedge clk);
        chk("R8 clr_par only", {par_err, frm_err}, 2'b01);
        clr_frm = 1; @(negedge clk); clr_frm = 0; @(negedge clk);
        chk("R8 clr_frm", frm_err, 0);

        // R4 second stop bit ignored
        set_cfg(0, 0, 0, 1);
        send(8'h6A, 0, 0, 0, 1, 0, 1, 0);
        chk("R4 second stop ignored frm", frm_err, 0);
        chk("R4 second stop ignored data", rx_data, 8'h6A);

        // R9 interrupts
        chk("R9 irq off", {irq_full, irq_err}, 2'b00);
        irq_en = 1; @(negedge clk);
        chk("R9 irq_full", {irq_full, irq_err}, 2'b10);
        clear_all();
        set_cfg(0, 0, 0, 0);
        send(8'h77, 0, 0, 0, 0, 0, 0, 1);
        chk("R9 irq_err", {irq_full, irq_err}, 2'b01);
        irq_en = 0; @(negedge clk);
        chk("R9 irq gated", irq_err, 0);
        clear_all();

        // R1 glitch shorter than half a bit
        rx_line = 0;
        repeat (4) @(negedge clk);
        rx_line = 1;
        repeat (OVS/2) @(negedge clk);
        chk("R1 glitch busy", busy, 0);
        repeat (3 * OVS) @(negedge clk);
        chk("R1 glitch flags", {rx_full, ovr_err, par_err, frm_err}, 0);
        chk("R1 glitch data", rx_data, 8'h6A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule